// File: doc/BRIEF.md
# Parallel Converter Bus Interface Emulator

This block stands in for the digital face of a 16-bit converter with a parallel output, so that a readout controller can be verified against cycle-accurate behaviour without any analog model. The controller drives an active-low chip select, a read/convert line and a byte select. The emulator answers with a busy flag and an 8-bit data bus with a separate drive enable. The word a conversion will return is taken from a side input at the moment the conversion starts.

All timing is counted in clock cycles. After a conversion starts, the previous result stays readable for a configurable number of cycles. Once that window closes, the bus carries a fixed marker word until the new result has been written. Busy rises one cycle after that write. A start request during a conversion is dropped, and a start pulse that is too short is flagged. Both flags are sticky until reset.

Top module: `conv_bus_emu`

## Requirements
- R1: A start is recognised at a clock edge where rd_cnv is sampled low, was sampled high at the previous edge, and cs_n is low. When busy is high, the start is accepted: sample_in is captured and busy reads low from the next cycle.
- R2: Busy stays low for exactly CONV_CYC cycles after the accepting edge, then returns high.
- R3: The result register takes the captured word one cycle before busy rises. The new word is on the bus in that cycle and after it.
- R4: For the first VALID_CYC cycles after the accepting edge (the cycles counted 0 to VALID_CYC-1), the bus still carries the previous result.
- R5: From cycle VALID_CYC until the result is updated, the bus carries the marker word BAD_WORD.
- R6: bus_oe is high exactly when rd_cnv is high and cs_n is low.
- R7: With byte_sel low, bus_data carries bits 15:8 of the word. With byte_sel high, it carries bits 7:0.
- R8: Codes are straight binary, passed through unchanged. For example, 0x0000, 0x8000, 0x7FFF and 0xFFFF read back as the same two bytes.
- R9: A start while busy is low is ignored: the busy timing and the returned word are unchanged. viol_busy is set and stays set until reset.
- R10: A falling rd_cnv while cs_n is high starts nothing. Busy stays high and the bus word is unchanged.
- R11: If rd_cnv of an accepted start is sampled low at fewer than MIN_PULSE clock edges (the accepting edge included), viol_pulse is set when rd_cnv rises. It stays set until reset.
- R12: During and after reset, busy is high, the result word is 0x0000, and both violation flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_cnv | input | 1 | High: read mode. Falling edge: start a conversion |
| byte_sel | input | 1 | 0: upper byte on the bus, 1: lower byte |
| sample_in | input | 16 | Word that the next conversion returns |
| busy | output | 1 | Low while a conversion runs |
| bus_data | output | 8 | Selected byte of the visible word |
| bus_oe | output | 1 | Bus drive enable. When low, the bus is tri-stated |
| viol_busy | output | 1 | Sticky: a start came in during a conversion |
| viol_pulse | output | 1 | Sticky: a start pulse was shorter than MIN_PULSE |

## Verification
Full conversions are run with a set of words that includes zero, midscale, one below midscale, full scale and two mixed patterns, with byte_sel toggled every cycle. These runs separate a swapped byte order, a wrong hold window, a late or early result write, and an off-by-one busy length. Pulse widths at and just above MIN_PULSE are set against a width one below it, which pins the comparison boundary. A second start in the middle of a conversion, and a falling rd_cnv with chip select high, show whether a request that should be ignored is wrongly accepted.

// File: rtl/conv_bus_emu_pkg.sv
package conv_bus_emu_pkg;

  // Byte lane selection: 0 -> upper half, 1 -> lower half.
  function automatic logic [7:0] pick_lane(input logic [15:0] word, input logic lower);
    return lower ? word[7:0] : word[15:8];
  endfunction

  // True while the old word has expired but the new one is not yet written.
  function automatic logic in_dead_window(input int cnt, input int hold_cyc, input int conv_cyc);
    return (cnt >= hold_cyc) && (cnt < conv_cyc - 1);
  endfunction

endpackage

// File: rtl/conv_bus_emu_ctrl.sv
module conv_bus_emu_ctrl
  import conv_bus_emu_pkg::*;
#(
  parameter int          CONV_CYC  = 800,
  parameter int          VALID_CYC = 500,
  parameter logic [15:0] BAD_WORD  = 16'hDEAD,
  localparam int         CW        = $clog2(CONV_CYC + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rd_cnv,
  input  logic [15:0] sample_in,
  output logic        busy,
  output logic        accept_evt,
  output logic [15:0] vis_word,
  output logic        viol_busy
);

  logic          rc_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [15:0]   pend_q;
  logic [15:0]   res_q;
  logic          vb_q;

  logic start_evt, ign_evt, upd_evt, fin_evt, dead_win;

  assign start_evt  = rc_q & ~rd_cnv & ~cs_n;
  assign accept_evt = start_evt & busy_q;
  assign ign_evt    = start_evt & ~busy_q;
  assign upd_evt    = ~busy_q && (int'(cnt_q) == CONV_CYC - 2);
  assign fin_evt    = ~busy_q && (int'(cnt_q) == CONV_CYC - 1);
  assign dead_win   = ~busy_q && in_dead_window(int'(cnt_q), VALID_CYC, CONV_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rc_q   <= 1'b1;
      busy_q <= 1'b1;
      cnt_q  <= '0;
      pend_q <= '0;
      res_q  <= '0;
      vb_q   <= 1'b0;
    end else begin
      rc_q <= rd_cnv;
      if (accept_evt) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        pend_q <= sample_in;
      end else if (fin_evt) begin
        busy_q <= 1'b1;
      end else if (!busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (upd_evt) res_q <= pend_q;
      if (ign_evt) vb_q <= 1'b1;
    end
  end

  assign busy      = busy_q;
  assign vis_word  = dead_win ? BAD_WORD : res_q;
  assign viol_busy = vb_q;

  AST_BUSY_FALLS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !busy_q); // R1
  AST_BUSY_LOW_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (int'($past(cnt_q)) == CONV_CYC - 1)); // R2
  AST_RESULT_BEFORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(upd_evt, 2)); // R3
  AST_RESULT_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> $past(upd_evt)); // R3
  AST_IGNORED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ign_evt |=> vb_q); // R9
  AST_IGNORED_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ign_evt && !fin_evt) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R9
  AST_BUSY_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vb_q) |-> vb_q); // R9

endmodule

// File: rtl/conv_bus_emu_pulse.sv
module conv_bus_emu_pulse #(
  parameter int  MIN_PULSE = 4,
  localparam int PW        = $clog2(MIN_PULSE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_evt,
  input  logic rd_cnv,
  output logic viol_pulse
);

  logic          trk_q;
  logic [PW-1:0] pw_q;
  logic          vp_q;
  logic          end_evt, short_evt;

  assign end_evt   = trk_q & rd_cnv & ~accept_evt;
  assign short_evt = end_evt && (int'(pw_q) < MIN_PULSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_q <= 1'b0;
      pw_q  <= '0;
      vp_q  <= 1'b0;
    end else begin
      if (accept_evt) begin
        trk_q <= 1'b1;
        pw_q  <= PW'(1);
      end else if (end_evt) begin
        trk_q <= 1'b0;
      end else if (trk_q && int'(pw_q) < MIN_PULSE) begin
        pw_q <= pw_q + 1'b1;
      end
      if (short_evt) vp_q <= 1'b1;
    end
  end

  assign viol_pulse = vp_q;

  AST_SHORT_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    short_evt |=> vp_q); // R11
  AST_PULSE_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vp_q) |-> vp_q); // R11

endmodule

// File: rtl/conv_bus_emu_outmux.sv
module conv_bus_emu_outmux
  import conv_bus_emu_pkg::*;
(
  input  logic        cs_n,
  input  logic        rd_cnv,
  input  logic        byte_sel,
  input  logic [15:0] vis_word,
  output logic [7:0]  bus_data,
  output logic        bus_oe
);

  assign bus_oe   = rd_cnv & ~cs_n;
  assign bus_data = pick_lane(vis_word, byte_sel);

endmodule

// File: rtl/conv_bus_emu.sv
module conv_bus_emu #(
  parameter int          CONV_CYC  = 800,
  parameter int          VALID_CYC = 500,
  parameter int          MIN_PULSE = 4,
  parameter logic [15:0] BAD_WORD  = 16'hDEAD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rd_cnv,
  input  logic        byte_sel,
  input  logic [15:0] sample_in,
  output logic        busy,
  output logic [7:0]  bus_data,
  output logic        bus_oe,
  output logic        viol_busy,
  output logic        viol_pulse
);

  logic        accept_evt;
  logic [15:0] vis_word;

  conv_bus_emu_ctrl #(
    .CONV_CYC (CONV_CYC),
    .VALID_CYC(VALID_CYC),
    .BAD_WORD (BAD_WORD)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_cnv    (rd_cnv),
    .sample_in (sample_in),
    .busy      (busy),
    .accept_evt(accept_evt),
    .vis_word  (vis_word),
    .viol_busy (viol_busy)
  );

  conv_bus_emu_pulse #(
    .MIN_PULSE(MIN_PULSE)
  ) i_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_evt(accept_evt),
    .rd_cnv    (rd_cnv),
    .viol_pulse(viol_pulse)
  );

  conv_bus_emu_outmux i_outmux (
    .cs_n    (cs_n),
    .rd_cnv  (rd_cnv),
    .byte_sel(byte_sel),
    .vis_word(vis_word),
    .bus_data(bus_data),
    .bus_oe  (bus_oe)
  );

  initial begin
    AST_CFG_ORDER: assert (CONV_CYC >= 2 && VALID_CYC >= 1 && MIN_PULSE >= 1); // R2
  end

endmodule

// File: tb/test_conv_bus_emu.sv
module test_conv_bus_emu;

  localparam int          CC  = 12;
  localparam int          VC  = 5;
  localparam int          MP  = 3;
  localparam logic [15:0] BAD = 16'hC35A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b0;
  logic        rd_cnv = 1'b1;
  logic        byte_sel = 1'b0;
  logic [15:0] sample_in = '0;
  logic        busy, bus_oe, viol_busy, viol_pulse;
  logic [7:0]  bus_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] last_res = 16'h0000;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  conv_bus_emu #(
    .CONV_CYC(CC), .VALID_CYC(VC), .MIN_PULSE(MP), .BAD_WORD(BAD)
  ) i_conv_bus_emu (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_cnv(rd_cnv), .byte_sel(byte_sel),
    .sample_in(sample_in), .busy(busy), .bus_data(bus_data), .bus_oe(bus_oe),
    .viol_busy(viol_busy), .viol_pulse(viol_pulse)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Read both lanes of the visible word and compare against the expected word.
  task automatic chk_word(input string req, input logic [15:0] exp);
    byte_sel = 1'b0; #1;
    chk(req, {8'h0, bus_data}, {8'h0, exp[15:8]});
    byte_sel = 1'b1; #1;
    chk(req, {8'h0, bus_data}, {8'h0, exp[7:0]});
  endtask

  // One conversion: pulse low for w edges; optional second start at cycle ek.
  task automatic run_conv(input logic [15:0] word, input int w, input int ek, input logic [15:0] other);
    logic [15:0] exp;
    @(negedge clk);
    sample_in = word;
    rd_cnv = 1'b0;
    for (int k = 0; k <= CC + 1; k++) begin
      @(negedge clk);
      chk("R2 busy", {15'h0, busy}, {15'h0, (k >= CC)});
      if (k < VC)           exp = last_res;  // R4
      else if (k < CC - 1)  exp = BAD;       // R5
      else                  exp = word;      // R3
      chk_word(k < VC ? "R4 hold" : (k < CC - 1 ? "R5 dead" : "R3 new"), exp);
      chk("R6 oe", {15'h0, bus_oe}, {15'h0, rd_cnv});
      sample_in = ~word;
      if (k == w - 1) rd_cnv = 1'b1;
      if (ek >= 0 && k == ek) begin rd_cnv = 1'b0; sample_in = other; end
      if (ek >= 0 && k == ek + 2) rd_cnv = 1'b1;
    end
    last_res = word;
  endtask

  initial begin
    logic [15:0] words [6];
    words[0] = 16'h0000; words[1] = 16'h8000; words[2] = 16'h7FFF;
    words[3] = 16'hFFFF; words[4] = 16'hA5C3; words[5] = 16'h1E96;

    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", {15'h0, busy}, 16'h1);
    chk("R12 vb", {15'h0, viol_busy}, 16'h0);
    chk("R12 vp", {15'h0, viol_pulse}, 16'h0);
    chk_word("R12 word", 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R7 R8 sweep over codes and pulse widths at/above the minimum
    for (int i = 0; i < 6; i++)
      for (int w = MP; w <= MP + 1; w++) begin
        run_conv(words[i], w, -1, 16'h0);
        chk("R8 code", {bus_data, bus_data}, {words[i][7:0], words[i][7:0]});
      end
    chk("R11 no flag", {15'h0, viol_pulse}, 16'h0);
    chk("R9 no flag", {15'h0, viol_busy}, 16'h0);

    // R10 falling with chip select high, R6 enable off
    @(negedge clk);
    cs_n = 1'b1; #1;
    chk("R6 oe cs high", {15'h0, bus_oe}, 16'h0);
    @(negedge clk);
    rd_cnv = 1'b0; sample_in = 16'h4242;
    repeat (3) @(negedge clk);
    chk("R10 busy", {15'h0, busy}, 16'h1);
    chk_word("R10 word", last_res);
    #1;
    chk("R6 oe read low", {15'h0, bus_oe}, 16'h0);
    rd_cnv = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);

    // R9 second start mid-conversion
    run_conv(16'h3C69, MP, 4, 16'h9999);
    chk("R9 flag", {15'h0, viol_busy}, 16'h1);
    chk_word("R9 word kept", 16'h3C69);
    chk("R11 still clear", {15'h0, viol_pulse}, 16'h0);

    // R11 pulse one edge short of the minimum
    run_conv(16'h0F0F, MP - 1, -1, 16'h0);
    chk("R11 flag", {15'h0, viol_pulse}, 16'h1);
    chk("R9 sticky", {15'h0, viol_busy}, 16'h1);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule